// File: doc/BRIEF.md
# Sample rate to log pitch converter

This block turns a 32-bit unsigned sample rate into a base-2 logarithmic pitch word. The integer part of the logarithm sits above a 20-bit fraction in the result. The rate is first multiplied by a fixed scale constant so that a 48 kHz rate lands just above 2^29. The block then finds the most significant set bit of the scaled value and shifts that bit to the top. The seven bits below it select one of 128 log segments, and the next seven bits interpolate linearly inside the chosen segment.

Both tables are built when the design is elaborated, so no table content is written out. Entry k of the magnitude table holds the 20-bit fraction of log2(1 + k/128). The slope of a segment is the rise to the next entry divided by 128 and rounded. For the last segment, the rise is measured to 2^20.

The pipeline has three stages: scale, normalize, and lookup with multiply-add. It takes one rate per cycle through a valid/ready pair. Each result appears three cycles after its rate is accepted, with a one-cycle valid strobe.

Top module: `rate2pitch`

## Requirements
- R1: While reset is high, outValid and pitchOut are 0 and inReady is low. One cycle after reset falls, inReady is high and stays high.
- R2: A rate accepted on a rising edge (inValid and inReady both high) gives outValid high after the third following edge. Back-to-back rates give back-to-back results in order, one per accepted rate, and pitchOut changes only when outValid is high.
- R3: A rate of 0 gives a pitchOut of 0.
- R4: A rate whose scaled value equals 1 gives a pitchOut of 0.
- R5: The scaled value is the low 32 bits of rate × 11185. Any overflow past bit 31 is discarded before the leading bit is searched.
- R6: A scaled value of exactly 2^i, for i from 1 to 31, gives pitchOut = (i − 15) × 2^20, taken modulo 2^32. For i below 15 this is a negative number in two's complement.
- R7: Doubling a scaled value whose bit 31 is clear raises pitchOut by exactly 2^20.
- R8: For any scaled value s > 1, pitchOut read as a signed 32-bit number lies within 256 of 2^20 × (log2(s) − 15).
- R9: Scaled-value bits more than 14 places below the leading set bit have no effect on pitchOut.
- R10: A cycle with inValid low produces no result three cycles later, whatever inRate holds in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A rate is offered on inRate |
| inReady | output | 1 | The block accepts a rate this cycle |
| inRate | input | 32 | Unsigned sample rate |
| outValid | output | 1 | pitchOut carries a new result this cycle |
| pitchOut | output | 32 | Log pitch: signed exponent above a 20-bit fraction |

## Verification
The bound checker watches the handshake timing on every cycle. It checks that each accepted rate yields a valid strobe three cycles later, that each idle cycle yields none, that inReady holds after reset, that a zero rate yields zero, and that the output word moves only with its strobe. The numeric content is shown only by the bench's sweeps. These cover every power-of-two scaled value, the lone-bit-zero case, exact exponent steps under doubling, and an accuracy bound across all 128 segments at several exponents. They also cover wrapped scaling products and the insensitivity to bits below the interpolation field.

// File: rtl/rate2pitch_pkg.sv
package rate2pitch_pkg;

  localparam int RATE_W  = 32;
  localparam int SCALE   = 11185;
  localparam int FRAC_W  = 20;
  localparam int IDX_W   = 7;
  localparam int LIN_W   = 7;
  localparam int SLOPE_W = 8;
  localparam int BIAS    = 15;
  localparam int SEGS    = 1 << IDX_W;
  localparam int POS_W   = $clog2(RATE_W);

  typedef struct packed {
    logic ldScale;
    logic ldNorm;
    logic ldOut;
  } pipeStrobe_t;

  typedef logic [SEGS-1:0][FRAC_W-1:0]  magTab_t;
  typedef logic [SEGS-1:0][SLOPE_W-1:0] slopeTab_t;

  // Bitwise binary log of (SEGS+k)/SEGS by repeated squaring in Q2.30
  function automatic logic [FRAC_W-1:0] logFrac(input int k);
    logic [63:0] x;
    logic [FRAC_W-1:0] f;
    x = 64'(SEGS + k) << (30 - IDX_W);
    f = '0;
    for (int b = FRAC_W - 1; b >= 0; b--) begin
      x = (x * x) >> 30;
      if (x >= (64'd2 << 30)) begin
        f[b] = 1'b1;
        x = x >> 1;
      end
    end
    return f;
  endfunction

  function automatic magTab_t buildMag();
    magTab_t t;
    for (int k = 0; k < SEGS; k++) t[k] = logFrac(k);
    return t;
  endfunction

  // Rise of each segment spread over 2^LIN_W interpolation steps, rounded
  function automatic slopeTab_t buildSlope();
    slopeTab_t t;
    int lo, hi, d;
    for (int k = 0; k < SEGS; k++) begin
      lo = int'(logFrac(k));
      hi = (k == SEGS - 1) ? (1 << FRAC_W) : int'(logFrac(k + 1));
      d  = hi - lo;
      t[k] = SLOPE_W'((d + (1 << (LIN_W - 1))) >> LIN_W);
    end
    return t;
  endfunction

endpackage

// File: rtl/rate2pitch_ctrl.sv
module rate2pitch_ctrl
  import rate2pitch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  output pipeStrobe_t strobe,
  output logic        outValid
);

  localparam int STAGES = 3;

  logic readyQ;
  logic [STAGES-1:0] vldQ;
  logic accept;

  assign accept  = inValid & readyQ;
  assign inReady = readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ <= 1'b0;
      vldQ   <= '0;
    end else begin
      readyQ <= 1'b1;
      vldQ   <= {vldQ[STAGES-2:0], accept};
    end
  end

  always_comb begin
    strobe.ldScale = accept;
    strobe.ldNorm  = vldQ[0];
    strobe.ldOut   = vldQ[1];
  end

  assign outValid = vldQ[STAGES-1];

endmodule

// File: rtl/rate2pitch_dp.sv
module rate2pitch_dp
  import rate2pitch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  pipeStrobe_t       strobe,
  input  logic [RATE_W-1:0] inRate,
  output logic [RATE_W-1:0] pitchOut
);

  localparam magTab_t   MAG_TAB   = buildMag();
  localparam slopeTab_t SLOPE_TAB = buildSlope();
  localparam int IDX_HI = RATE_W - 2;
  localparam int LIN_HI = IDX_HI - IDX_W;

  // Stage 1: scale
  logic [RATE_W-1:0] scaledQ;
  always_ff @(posedge clk) begin
    if (rst) scaledQ <= '0;
    else if (strobe.ldScale) scaledQ <= inRate * RATE_W'(SCALE);
  end

  // Stage 2: leading-one detect and normalize
  logic [POS_W-1:0]  leadPos;
  logic              leadHit;
  logic [RATE_W-1:0] normVal;

  always_comb begin
    leadPos = '0;
    leadHit = 1'b0;
    for (int i = 1; i < RATE_W; i++) begin
      if (scaledQ[i]) begin
        leadPos = POS_W'(i);
        leadHit = 1'b1;
      end
    end
  end

  assign normVal = scaledQ << (POS_W'(RATE_W - 1) - leadPos);

  logic [RATE_W-1:0] normQ;
  logic [POS_W-1:0]  expQ;
  logic              hitQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      normQ <= '0;
      expQ  <= '0;
      hitQ  <= 1'b0;
    end else if (strobe.ldNorm) begin
      normQ <= normVal;
      expQ  <= leadPos;
      hitQ  <= leadHit;
    end
  end

  // Stage 3: table lookup and interpolation
  logic [IDX_W-1:0]  segIdx;
  logic [LIN_W-1:0]  linFrac;
  logic [RATE_W-1:0] expTerm;
  logic [RATE_W-1:0] interp;
  logic [RATE_W-1:0] sumVal;

  assign segIdx  = normQ[IDX_HI -: IDX_W];
  assign linFrac = normQ[LIN_HI -: LIN_W];
  assign expTerm = (RATE_W'(expQ) - RATE_W'(BIAS)) << FRAC_W;
  assign interp  = RATE_W'(linFrac) * RATE_W'(SLOPE_TAB[segIdx]);
  assign sumVal  = expTerm + RATE_W'(MAG_TAB[segIdx]) + interp;

  logic [RATE_W-1:0] pitchQ;
  always_ff @(posedge clk) begin
    if (rst) pitchQ <= '0;
    else if (strobe.ldOut) pitchQ <= hitQ ? sumVal : '0;
  end

  assign pitchOut = pitchQ;

endmodule

// File: rtl/rate2pitch.sv
module rate2pitch
  import rate2pitch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inRate,
  output logic        outValid,
  output logic [31:0] pitchOut
);

  pipeStrobe_t strobe;

  rate2pitch_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .strobe   (strobe),
    .outValid (outValid)
  );

  rate2pitch_dp dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inRate   (inRate),
    .pitchOut (pitchOut)
  );

endmodule

// File: rtl/rate2pitch_chk.sv
module rate2pitch_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inReady,
  input logic [31:0] inRate,
  input logic        outValid,
  input logic [31:0] pitchOut
);

  // R2
  accepted_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |-> ##3 outValid);

  // R10
  idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !(inValid && inReady) |-> ##3 !outValid);

  // R3
  zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inRate == 32'd0) |-> ##3 (pitchOut == 32'd0));

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> inReady);

  // R2
  out_moves_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pitchOut) |-> outValid);

endmodule

bind rate2pitch rate2pitch_chk chk_i (.*);

// File: tb/rate2pitch_tb_top.sv
`timescale 1ns/1ps
module rate2pitch_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inRate = '0;
  logic        inReady;
  logic        outValid;
  logic [31:0] pitchOut;

  rate2pitch dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inRate(inRate), .outValid(outValid), .pitchOut(pitchOut)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] outArr[$];
  logic [31:0] rateQ[$];
  logic [31:0] inv;
  logic [31:0] seed = 32'h1234_5678;

  always @(negedge clk) if (!rst && outValid) outArr.push_back(pitchOut);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sc(input logic [31:0] r);
    return r * 32'd11185;
  endfunction

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic accChk(input logic [31:0] s, input logic [31:0] act, input string tag);
    real ideal, diff;
    int idealI;
    if (s <= 32'd1) chk(act == 32'd0, tag, act, 32'd0);
    else begin
      ideal  = 1048576.0 * ($ln(real'(s)) / $ln(2.0) - 15.0);
      diff   = real'($signed(act)) - ideal;
      idealI = $rtoi(ideal);
      chk(diff <= 256.0 && diff >= -256.0, tag, act, 32'(idealI));
    end
  endtask

  task automatic stream();
    outArr.delete();
    foreach (rateQ[j]) begin
      @(negedge clk);
      inValid = 1'b1;
      inRate  = rateQ[j];
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    chk(outArr.size() == rateQ.size(), "R2 result count", 32'(outArr.size()), 32'(rateQ.size()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    x = 32'd11185;
    repeat (5) x = x * (32'd2 - 32'd11185 * x);
    inv = x;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", 32'(outValid), 32'd0);
    chk(pitchOut == 32'd0, "R1 pitchOut in reset", pitchOut, 32'd0);
    chk(inReady == 1'b0, "R1 inReady in reset", 32'(inReady), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(inReady == 1'b1, "R1 inReady after reset", 32'(inReady), 32'd1);

    // R2 latency, R5 scaling of 48000 -> exact 14 << 20
    @(negedge clk);
    inValid = 1'b1; inRate = 32'd48000;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b0, "R2 latency cycle 1", 32'(outValid), 32'd0);
    @(negedge clk);
    chk(outValid == 1'b0, "R2 latency cycle 2", 32'(outValid), 32'd0);
    @(negedge clk);
    chk(outValid == 1'b1, "R2 latency cycle 3", 32'(outValid), 32'd1);
    chk(pitchOut == 32'h00E0_0000, "R5 48000 result", pitchOut, 32'h00E0_0000);
    @(negedge clk);
    chk(outValid == 1'b0, "R2 single strobe", 32'(outValid), 32'd0);
    repeat (3) @(negedge clk);

    // R3, R4, R6
    rateQ.delete();
    rateQ.push_back(32'd0);
    rateQ.push_back(inv);
    for (int i = 1; i < 32; i++) rateQ.push_back(inv << i);
    stream();
    if (outArr.size() == rateQ.size()) begin
      chk(outArr[0] == 32'd0, "R3 zero rate", outArr[0], 32'd0);
      chk(outArr[1] == 32'd0, "R4 scaled value one", outArr[1], 32'd0);
      for (int i = 1; i < 32; i++) begin
        logic [31:0] e;
        e = (32'(i) - 32'd15) << 20;
        chk(outArr[i + 1] == e, "R6 power of two", outArr[i + 1], e);
      end
    end

    // R7 doubling
    rateQ.delete();
    for (int j = 0; j < 64; j++) begin
      logic [31:0] s;
      s = (nextRand() & 32'h3FFF_FFFF) | 32'h2;
      rateQ.push_back(inv * s);
      rateQ.push_back(inv * (s << 1));
    end
    stream();
    if (outArr.size() == rateQ.size())
      for (int j = 0; j < 64; j++) begin
        logic [31:0] d;
        d = outArr[2 * j + 1] - outArr[2 * j];
        chk(d == 32'h0010_0000, "R7 doubling step", d, 32'h0010_0000);
      end

    // R8 segment sweep at several exponents plus scattered values
    rateQ.delete();
    for (int k = 0; k < 128; k++) begin
      logic [31:0] top;
      top = {1'b1, 7'(k), 24'h5A_C3E1};
      rateQ.push_back(inv * (top >> 27));
      rateQ.push_back(inv * (top >> 16));
      rateQ.push_back(inv * (top >> 7));
      rateQ.push_back(inv * top);
    end
    for (int j = 0; j < 512; j++) rateQ.push_back(nextRand() >> (j % 24));
    stream();
    if (outArr.size() == rateQ.size())
      foreach (rateQ[j]) accChk(sc(rateQ[j]), outArr[j], "R8 accuracy");

    // R5 wrapped products
    rateQ.delete();
    rateQ.push_back(32'hFFFF_FFFF);
    rateQ.push_back(32'h8000_0000);
    rateQ.push_back(32'h1234_5678);
    rateQ.push_back(32'hC000_0001);
    stream();
    if (outArr.size() == rateQ.size()) begin
      foreach (rateQ[j]) accChk(sc(rateQ[j]), outArr[j], "R5 wrapped scale");
      chk(outArr[1] == 32'h0100_0000, "R5 wrap to bit 31", outArr[1], 32'h0100_0000);
    end

    // R9 low bits ignored
    rateQ.delete();
    for (int k = 0; k < 128; k++) begin
      logic [31:0] base;
      base = {1'b1, 7'(k), 7'h55, 17'h0};
      rateQ.push_back(inv * base);
      rateQ.push_back(inv * (base | 32'h0001_FFFF));
      rateQ.push_back(inv * (base >> 11));
      rateQ.push_back(inv * ((base >> 11) | 32'h3F));
    end
    stream();
    if (outArr.size() == rateQ.size())
      for (int k = 0; k < 256; k++)
        chk(outArr[2 * k] == outArr[2 * k + 1], "R9 low bits", outArr[2 * k + 1], outArr[2 * k]);

    // R10 idle cycles with changing rate
    outArr.delete();
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      inValid = 1'b0;
      inRate  = nextRand();
    end
    repeat (5) @(negedge clk);
    chk(outArr.size() == 0, "R10 no result when idle", 32'(outArr.size()), 32'd0);
    rateQ.delete();
    rateQ.push_back(inv << 20);
    stream();
    if (outArr.size() == 1)
      chk(outArr[0] == 32'h0050_0000, "R10 result after idle", outArr[0], 32'h0050_0000);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule